// File: doc/BRIEF.md
# Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles. It uses bit-pair recoding of the multiplier. A one-cycle `start` pulse is accepted while the block is idle. The pulse captures the multiplicand and the multiplier and starts a run of exactly `WIDTH` steps.

In each step the block looks at the lowest multiplier bit together with a guard bit that sits just below it. From that pair it adds the multiplicand into the accumulator, subtracts it, or leaves the accumulator alone. It then shifts accumulator, multiplier register and guard bit one place right as a single arithmetic shift.

When the last step has been applied, the signed double-width product is registered and `done` pulses for one cycle. The product stays on the port until the next run completes. The accumulator is one bit wider than the operands, so the most negative multiplicand gives the correct result.

Top module: `booth_mult`

## Requirements
- R1: After synchronous reset, `busy` and `done` are low and `product` is zero.
- R2: A `start` sampled high while `busy` is low loads the operands, clears the accumulator and the guard bit, and `busy` is high from the next cycle.
- R3: In each step the pair (multiplier LSB, guard bit) selects the action: 10 subtracts the multiplicand from the accumulator, 01 adds it, and 00 or 11 leave the accumulator unchanged. A multiplier of 0 therefore gives a product of 0, and a multiplier of all ones gives the negated multiplicand.
- R4: The right shift after each action is arithmetic across accumulator, multiplier register and guard bit. Every sign combination of the operands yields the exact signed product, with no correction step.
- R5: `done` is high in the cycle that follows the `WIDTH`-th clock edge after the edge that sampled `start`, and is low in all the cycles before it.
- R6: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R7: `product` changes only in the cycle in which `done` rises. A `start` sampled while `busy` is high is ignored: it does not change the running operation or its result, and it produces no extra `done`.
- R8: The most negative operand values are handled. With `WIDTH`=4, −8 × −8 gives +64 (8'h40) and −8 × 7 gives −56 (8'hC8).
- R9: With `WIDTH`=4, 7 × 3 ends with the upper half 0001 and the lower half 0101, so the product is 8'h15 (21).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| op_a | input | WIDTH | Signed multiplicand |
| op_b | input | WIDTH | Signed multiplier |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product, held until the next completion |

## Verification
The hardest case to reach from the ports is the subtract step with the most negative multiplicand. In that step A−M leaves the signed range of an operand-width accumulator, and it occurs only when the multiplier's low bit pair reads 10. The bench runs every operand pair of the 4-bit configuration, which includes −8 as the multiplicand against every multiplier pattern. Separate tasks cover the fixed recoding patterns (all zeros, all ones, alternating bits), a second `start` pulsed in the middle of a run, and the exact cycle on which `done` appears.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      q_lsb,
  input  logic      q_guard,
  output booth_op_e op
);
  always_comb begin
    unique case ({q_lsb, q_guard})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   acc,
  input  logic [WIDTH-1:0] mq,
  input  logic [WIDTH:0]   mcand,
  input  booth_op_e        op,
  output logic [WIDTH:0]   acc_nxt,
  output logic [WIDTH-1:0] mq_nxt,
  output logic             guard_nxt
);
  logic [WIDTH:0] sum;

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc + mcand;
      OP_SUB:  sum = acc - mcand;
      default: sum = acc;
    endcase
    acc_nxt   = {sum[WIDTH], sum[WIDTH:1]};
    mq_nxt    = {sum[0], mq[WIDTH-1:1]};
    guard_nxt = mq[0];
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic load,
  output logic last
);
  logic [CW-1:0] cnt;

  assign load = start && !busy;
  assign last = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= CW'(WIDTH);
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (last) busy <= 1'b0;
    end
  end

  p_cnt_live_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0));
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && cnt == $past(cnt) - CW'(1)));
  p_finish_r5: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    product
);
  logic [WIDTH:0]   acc, acc_nxt, mcand;
  logic [WIDTH-1:0] mq, mq_nxt;
  logic             guard, guard_nxt;
  logic             load, last;
  booth_op_e        op;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .load(load), .last(last)
  );

  booth_recode u_recode (.q_lsb(mq[0]), .q_guard(guard), .op(op));

  booth_step #(.WIDTH(WIDTH)) u_step (
    .acc(acc), .mq(mq), .mcand(mcand), .op(op),
    .acc_nxt(acc_nxt), .mq_nxt(mq_nxt), .guard_nxt(guard_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      mq      <= '0;
      guard   <= 1'b0;
      mcand   <= '0;
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        acc   <= '0;
        guard <= 1'b0;
        mq    <= op_b;
        mcand <= {op_a[WIDTH-1], op_a};
      end else if (busy) begin
        acc   <= acc_nxt;
        mq    <= mq_nxt;
        guard <= guard_nxt;
        if (last) product <= {acc_nxt[WIDTH-1:0], mq_nxt};
      end
    end
  end

  p_load_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && acc == '0 && !guard));
  p_sub_on_10_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && mq[0] && !guard) |-> (op == OP_SUB));
  p_add_on_01_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !mq[0] && guard) |-> (op == OP_ADD));
  p_sign_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (acc[WIDTH] == acc[WIDTH-1] || $past(op) != OP_HOLD));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_hold_product_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
endmodule

// File: tb/booth_mult_tb.sv
module booth_mult_tb;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  op_a = '0, op_b = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  booth_mult #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return PW'(p);
  endfunction

  // One multiplication; optional start pulse in the middle of the run.
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input string req, input bit timing, input bit disturb);
    logic [PW-1:0] exp;
    exp = ref_prod(a, b);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (timing) check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int k = 1; k <= W; k++) begin
      if (disturb && k == 2) begin
        op_a = ~a; op_b = ~b; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (k < W) begin
        if (timing) check(done == 1'b0, "R5 done early", int'(done), 0);
      end else begin
        check(done == 1'b1, "R5 done on last step", int'(done), 1);
        check(busy == 1'b0, "R6 busy low with done", int'(busy), 0);
        check(product == exp, req, int'(product), int'(exp));
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", int'(done), 0);
    check(product == exp, "R7 product held", int'(product), int'(exp));
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(product == '0, "R1 product after reset", int'(product), 0);
  endtask

  task automatic t_example;
    run_mul(4'd7, 4'd3, "R9 7x3", 1'b1, 1'b0);
    check(product[PW-1:W] == 4'b0001, "R9 upper half", int'(product[PW-1:W]), 1);
    check(product[W-1:0] == 4'b0101, "R9 lower half", int'(product[W-1:0]), 5);
  endtask

  task automatic t_recode_patterns;
    run_mul(4'd5, 4'b0000, "R3 multiplier zero", 1'b0, 1'b0);
    run_mul(4'd5, 4'b1111, "R3 multiplier all ones", 1'b0, 1'b0);
    run_mul(4'd3, 4'b0101, "R3 alternating 0101", 1'b0, 1'b0);
    run_mul(4'd3, 4'b1010, "R3 alternating 1010", 1'b0, 1'b0);
  endtask

  task automatic t_signs;
    run_mul(4'd6, 4'b1101, "R4 pos x neg", 1'b0, 1'b0);
    run_mul(4'b1101, 4'd6, "R4 neg x pos", 1'b0, 1'b0);
    run_mul(4'b1011, 4'b1110, "R4 neg x neg", 1'b0, 1'b0);
  endtask

  task automatic t_extremes;
    run_mul(4'b1000, 4'b1000, "R8 -8 x -8", 1'b1, 1'b0);
    check(product == 8'h40, "R8 -8 x -8 value", int'(product), 64);
    run_mul(4'b1000, 4'd7, "R8 -8 x 7", 1'b0, 1'b0);
    check(product == 8'hC8, "R8 -8 x 7 value", int'(product), 200);
  endtask

  task automatic t_start_while_busy;
    run_mul(4'd6, 4'd5, "R7 start ignored while busy", 1'b1, 1'b1);
    for (int k = 0; k < W + 2; k++) begin
      @(negedge clk);
      check(done == 1'b0, "R7 no extra done", int'(done), 0);
      check(product == 8'd30, "R7 product unchanged", int'(product), 30);
    end
  endtask

  task automatic t_exhaustive;
    for (int i = -8; i < 8; i++)
      for (int j = -8; j < 8; j++)
        run_mul(W'(i), W'(j), "R4 exhaustive signed product", 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_example();
    t_recode_patterns();
    t_signs();
    t_extremes();
    t_start_while_busy();
    t_exhaustive();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule